// File: doc/BRIEF.md
# Oversampling serial receiver with sticky error status

This block turns an asynchronous serial line into bytes. The line is sampled once per pulse of a tick input that runs at sixteen times the bit rate. A falling edge on the idle line starts a frame. The start bit is confirmed half a bit later. Data bits are then taken at the middle of each bit, least significant bit first. An optional parity bit and one or two stop bits follow. Each completed character is offered on a single-cycle push interface to a receive FIFO that lives outside the block.

Three error classes are kept as sticky flags in a status word: parity mismatch, framing and receive overrun. Each class has its own detect-enable bit in the configuration word. Software never has to read-modify-write the status. A separate write-only strobe word sets or clears the receiver enable and clears each flag on its own bit. While any flag is set, the error request output stays high.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset the receiver is disabled, `status_word` is zero, `err_req` is low and nothing is pushed.
- R2: A strobe write with bit 1 set enables the receiver and one with bit 0 set disables it. Bit 0 wins when both are set. While the receiver is disabled, traffic on `rxd` pushes nothing.
- R3: With configuration bits [2:0] = 0 (8-bit mode), a frame of start bit, 8 data bits sent LSB first and a stop bit is pushed as one byte. Each bit lasts 16 pulses of `tick16`, and `push_valid` is high for exactly one cycle.
- R4: With configuration bits [2:0] = 2, seven data bits are received and the pushed byte has bit 7 at 0. Any other mode value is handled as 8-bit mode.
- R5: Configuration bit 3 adds a parity bit after the data, and bit 5 selects odd parity instead of even. A mismatch sets `status_word` bit 16 only when configuration bit 16 is set. The byte is pushed in either case.
- R6: With configuration bit 7 set, the receiver waits until the middle of a second stop bit before it looks for a new start edge. A low pulse inside that second stop bit therefore starts no frame. A start bit that is high again at its midpoint is discarded.
- R7: A low level at the middle of the first stop bit sets `status_word` bit 17 when configuration bit 17 is set. The byte is still pushed.
- R8: If `fifo_full` is high when a character completes, that character is not pushed. `status_word` bit 19 is set if configuration bit 19 is set.
- R9: Error flags stay set until cleared. Strobe bits 2, 3 and 5 clear only the parity, framing and overrun flag respectively. A clear in the same cycle as a new error of that class leaves the flag clear.
- R10: `err_req` is high exactly while at least one of `status_word` bits 16, 17 and 19 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling pulse, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_word | input | 32 | Frame and error-detect configuration |
| stb_we | input | 1 | Strobe word write enable |
| stb_word | input | 6 | Strobe bits: enable clear/set, flag clears |
| fifo_full | input | 1 | Downstream FIFO cannot accept a byte |
| push_valid | output | 1 | One-cycle push of a received character |
| push_data | output | 8 | Received character |
| rx_enabled | output | 1 | Receiver enable state |
| status_word | output | 32 | Sticky flags at bits 16, 17, 19 |
| err_req | output | 1 | Error request, high while any flag is set |

## Verification
Characters with asymmetric bit patterns such as 0xA5, 0x3C and 0xC1 are sent in 8-bit mode, in 7-bit mode and in an unlisted mode value. A swapped bit order, a wrong data-bit count or a lost top bit therefore all show up as a wrong byte. Parity frames use correct and deliberately wrong parity bits under both even and odd sense, with detection enabled and disabled, which separates sensing errors from gating errors. A low pulse that falls in the second stop bit is sent in two-stop mode and shows whether the receiver resumes start detection too early. A short low stop bit checks that framing is flagged without dropping the byte. A clear strobe issued in the very cycle a parity error completes shows whether clear priority holds.

// File: rtl/uart_rx_sticky_pkg.sv
package uart_rx_sticky_pkg;

  localparam int RX_DATA_W = 8;
  localparam int CFG_W     = 32;
  localparam int STB_W     = 6;
  localparam int NUM_ERR   = 3;

  // configuration word fields
  localparam int CFG_MODE_LO  = 0;
  localparam int CFG_PAR_ON   = 3;
  localparam int CFG_ODD      = 5;
  localparam int CFG_TWO_STOP = 7;
  localparam int CFG_PE_EN    = 16;
  localparam int CFG_FE_EN    = 17;
  localparam int CFG_ROE_EN   = 19;
  localparam logic [2:0] MODE_SEVEN = 3'd2;

  // status word flag positions, indexed by error class
  localparam int STAT_PE  = 16;
  localparam int STAT_FE  = 17;
  localparam int STAT_ROE = 19;

  // strobe word bits
  localparam int STB_EN_CLR  = 0;
  localparam int STB_EN_SET  = 1;
  localparam int STB_PE_CLR  = 2;
  localparam int STB_FE_CLR  = 3;
  localparam int STB_ROE_CLR = 5;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2
  } rx_state_t;

  typedef struct packed {
    logic seven;
    logic par_on;
    logic odd;
    logic two_stop;
    logic pe_en;
    logic fe_en;
    logic roe_en;
  } rx_cfg_t;

  function automatic rx_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    rx_cfg_t c;
    c.seven    = (w[CFG_MODE_LO +: 3] == MODE_SEVEN);
    c.par_on   = w[CFG_PAR_ON];
    c.odd      = w[CFG_ODD];
    c.two_stop = w[CFG_TWO_STOP];
    c.pe_en    = w[CFG_PE_EN];
    c.fe_en    = w[CFG_FE_EN];
    c.roe_en   = w[CFG_ROE_EN];
    return c;
  endfunction

  // index of the last data bit for the chosen character size
  function automatic logic [2:0] last_bit_idx(input logic seven);
    return seven ? 3'(RX_DATA_W - 2) : 3'(RX_DATA_W - 1);
  endfunction

  // total ones over data and parity must be even (odd=0) or odd (odd=1)
  function automatic logic parity_wrong(input logic [RX_DATA_W-1:0] d,
                                        input logic pbit, input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

  // sticky flag update: clear beats set
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return clr ? 1'b0 : (cur | set);
  endfunction

endpackage

// File: rtl/uart_rx_sticky_sync.sv
module uart_rx_sticky_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sticky_deframe.sv
module uart_rx_sticky_deframe
  import uart_rx_sticky_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 tick_i,
  input  logic                 rx_i,
  input  rx_cfg_t              cfg_i,
  output logic                 done_o,
  output logic [RX_DATA_W-1:0] data_o,
  output logic                 pbad_o,
  output logic                 fbad_o
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  rx_state_t            state;
  logic [CW-1:0]        cnt;
  logic [2:0]           idx;
  logic [RX_DATA_W-1:0] shreg;
  logic                 pbit;
  logic                 at_full, at_half;

  assign at_full = tick_i && (cnt == CW'(OVS - 1));
  assign at_half = tick_i && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      pbit   <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      pbad_o <= 1'b0;
      fbad_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else begin
        if (tick_i && state != RX_IDLE && !at_full && !(state == RX_START && at_half))
          cnt <= cnt + 1'b1;
        unique case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (!rx_i) state <= RX_START;
          end
          RX_START: if (at_half) begin
            cnt <= '0;
            if (!rx_i) begin
              state <= RX_DATA;
              idx   <= '0;
              shreg <= '0;
            end else begin
              state <= RX_IDLE;
            end
          end
          RX_DATA: if (at_full) begin
            cnt        <= '0;
            shreg[idx] <= rx_i;
            if (idx == last_bit_idx(cfg_i.seven))
              state <= cfg_i.par_on ? RX_PAR : RX_STOP1;
            else
              idx <= idx + 1'b1;
          end
          RX_PAR: if (at_full) begin
            cnt   <= '0;
            pbit  <= rx_i;
            state <= RX_STOP1;
          end
          RX_STOP1: if (at_full) begin
            cnt    <= '0;
            done_o <= 1'b1;
            data_o <= shreg;
            pbad_o <= cfg_i.par_on && parity_wrong(shreg, pbit, cfg_i.odd);
            fbad_o <= ~rx_i;
            state  <= cfg_i.two_stop ? RX_STOP2 : RX_IDLE;
          end
          RX_STOP2: if (at_full) begin
            cnt   <= '0;
            state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_sticky_errunit.sv
module uart_rx_sticky_errunit
  import uart_rx_sticky_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_we_i,
  input  logic [STB_W-1:0] stb_i,
  input  logic             done_i,
  input  logic             pbad_i,
  input  logic             fbad_i,
  input  logic             full_i,
  input  rx_cfg_t          cfg_i,
  output logic             rx_en_o,
  output logic [NUM_ERR-1:0] flags_o,
  output logic [NUM_ERR-1:0] evt_o
);
  logic [NUM_ERR-1:0] clr;

  // class order: 0 parity, 1 framing, 2 overrun
  assign evt_o[0] = done_i && pbad_i && cfg_i.pe_en;
  assign evt_o[1] = done_i && fbad_i && cfg_i.fe_en;
  assign evt_o[2] = done_i && full_i && cfg_i.roe_en;

  assign clr[0] = stb_we_i && stb_i[STB_PE_CLR];
  assign clr[1] = stb_we_i && stb_i[STB_FE_CLR];
  assign clr[2] = stb_we_i && stb_i[STB_ROE_CLR];

  generate
    for (genvar k = 0; k < NUM_ERR; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) flags_o[k] <= 1'b0;
        else        flags_o[k] <= sticky_next(flags_o[k], evt_o[k], clr[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              rx_en_o <= 1'b0;
    else if (stb_we_i && stb_i[STB_EN_CLR])  rx_en_o <= 1'b0;
    else if (stb_we_i && stb_i[STB_EN_SET])  rx_en_o <= 1'b1;
  end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
  import uart_rx_sticky_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 rxd,
  input  logic [CFG_W-1:0]     cfg_word,
  input  logic                 stb_we,
  input  logic [STB_W-1:0]     stb_word,
  input  logic                 fifo_full,
  output logic                 push_valid,
  output logic [RX_DATA_W-1:0] push_data,
  output logic                 rx_enabled,
  output logic [CFG_W-1:0]     status_word,
  output logic                 err_req
);
  rx_cfg_t              cfg;
  logic                 rx_s;
  logic                 frame_done;
  logic                 frame_pbad, frame_fbad;
  logic [RX_DATA_W-1:0] frame_data;
  logic [NUM_ERR-1:0]   flags, evts;
  logic                 pe_evt, fe_evt, ro_evt;

  assign cfg = decode_cfg(cfg_word);

  uart_rx_sticky_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd), .q_o(rx_s)
  );

  uart_rx_sticky_deframe #(.OVS(OVS)) u_deframe (
    .clk(clk), .rst_n(rst_n), .en_i(rx_enabled), .tick_i(tick16),
    .rx_i(rx_s), .cfg_i(cfg), .done_o(frame_done), .data_o(frame_data),
    .pbad_o(frame_pbad), .fbad_o(frame_fbad)
  );

  uart_rx_sticky_errunit u_err (
    .clk(clk), .rst_n(rst_n), .stb_we_i(stb_we), .stb_i(stb_word),
    .done_i(frame_done), .pbad_i(frame_pbad), .fbad_i(frame_fbad),
    .full_i(fifo_full), .cfg_i(cfg), .rx_en_o(rx_enabled),
    .flags_o(flags), .evt_o(evts)
  );

  assign pe_evt = evts[0];
  assign fe_evt = evts[1];
  assign ro_evt = evts[2];

  assign push_valid = frame_done && !fifo_full;
  assign push_data  = frame_data;

  always_comb begin
    status_word           = '0;
    status_word[STAT_PE]  = flags[0];
    status_word[STAT_FE]  = flags[1];
    status_word[STAT_ROE] = flags[2];
  end

  assign err_req = |flags;
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk
  import uart_rx_sticky_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stb_we,
  input logic [STB_W-1:0] stb_word,
  input logic             push_valid,
  input logic             rx_enabled,
  input logic [CFG_W-1:0] status_word,
  input logic             frame_done,
  input logic             ro_evt
);
  AST_EN_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stb_we && stb_word[STB_EN_CLR] |=> !rx_enabled); // R2
  AST_PUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> $past(rx_enabled)); // R2
  AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> !push_valid); // R3
  AST_OVR_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ro_evt |-> !push_valid); // R8
  AST_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ro_evt && !(stb_we && stb_word[STB_ROE_CLR]) |=> status_word[STAT_ROE]); // R8
  AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[STAT_PE] && !(stb_we && stb_word[STB_PE_CLR]) |=> status_word[STAT_PE]); // R9
  AST_FE_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stb_we && stb_word[STB_FE_CLR] |=> !status_word[STAT_FE]); // R9
  AST_FE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[STAT_FE]) |-> $past(frame_done)); // R7
endmodule

bind uart_rx_sticky uart_rx_sticky_chk chk_i (
  .clk(clk), .rst_n(rst_n), .stb_we(stb_we), .stb_word(stb_word),
  .push_valid(push_valid), .rx_enabled(rx_enabled),
  .status_word(status_word), .frame_done(frame_done), .ro_evt(ro_evt)
);

// File: tb/uart_rx_sticky_test.sv
`timescale 1ns/1ps
module uart_rx_sticky_test;
  localparam int BIT_CLK = 32; // tick every other clock, 16 ticks per bit

  logic        clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        stb_we = 1'b0;
  logic [5:0]  stb_word = '0;
  logic        fifo_full = 1'b0;
  logic        push_valid, rx_enabled, err_req;
  logic [7:0]  push_data;
  logic [31:0] status_word;

  int checks = 0, fails = 0, pushes = 0;
  logic [7:0] last_byte = '0;
  bit finished = 0;

  uart_rx_sticky uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_word(cfg_word),
    .stb_we(stb_we), .stb_word(stb_word), .fifo_full(fifo_full),
    .push_valid(push_valid), .push_data(push_data), .rx_enabled(rx_enabled),
    .status_word(status_word), .err_req(err_req)
  );

  initial forever #2.5 clk = ~clk;
  initial forever begin @(negedge clk); tick16 = ~tick16; end
  initial forever begin
    @(negedge clk);
    if (push_valid) begin pushes++; last_byte = push_data; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input logic [2:0] mode, input bit par,
      input bit odd, input bit two, input bit pe, input bit fe, input bit roe);
    logic [31:0] w = '0;
    w[2:0] = mode; w[3] = par; w[5] = odd; w[7] = two;
    w[16] = pe; w[17] = fe; w[19] = roe;
    return w;
  endfunction

  task automatic hold(input int nclk);
    repeat (nclk) @(negedge clk);
  endtask

  task automatic strobe(input logic [5:0] v);
    @(negedge clk); stb_we = 1'b1; stb_word = v;
    @(negedge clk); stb_we = 1'b0; stb_word = '0;
  endtask

  // stop_ok=0: first stop bit low for 10 ticks then high
  task automatic send(input logic [7:0] d, input int nbits, input bit par,
      input bit odd, input bit flip, input bit stop_ok, input int nstop);
    logic p;
    p = odd;
    @(negedge clk); rxd = 1'b0; hold(BIT_CLK);
    for (int i = 0; i < nbits; i++) begin rxd = d[i]; p ^= d[i]; hold(BIT_CLK); end
    if (par) begin rxd = p ^ flip; hold(BIT_CLK); end
    if (stop_ok) begin rxd = 1'b1; hold(BIT_CLK); end
    else begin rxd = 1'b0; hold(20); rxd = 1'b1; hold(BIT_CLK - 20); end
    if (nstop == 2) hold(BIT_CLK);
    hold(3 * BIT_CLK);
  endtask

  task automatic t_reset();
    hold(4);
    chk("R1 rx_enabled", rx_enabled, 0);
    chk("R1 status", status_word, 0);
    chk("R1 err_req", err_req, 0);
    chk("R1 pushes", pushes, 0);
  endtask

  task automatic t_enable();
    cfg_word = mkcfg(0, 0, 0, 0, 1, 1, 1);
    send(8'h55, 8, 0, 0, 0, 1, 1);
    chk("R2 disabled no push", pushes, 0);
    strobe(6'b000010);
    chk("R2 set enable", rx_enabled, 1);
    strobe(6'b000011);
    chk("R2 clear beats set", rx_enabled, 0);
    strobe(6'b000010);
  endtask

  task automatic t_eight();
    int n0 = pushes;
    send(8'hA5, 8, 0, 0, 0, 1, 1);
    chk("R3 byte A5", last_byte, 8'hA5);
    send(8'h3C, 8, 0, 0, 0, 1, 1);
    chk("R3 byte 3C", last_byte, 8'h3C);
    chk("R3 push count", pushes - n0, 2);
  endtask

  task automatic t_seven();
    cfg_word = mkcfg(3'd2, 0, 0, 0, 1, 1, 1);
    send(8'hD3, 7, 0, 0, 0, 1, 1);
    chk("R4 seven bit", last_byte, 8'h53);
    cfg_word = mkcfg(3'd3, 0, 0, 0, 1, 1, 1);
    send(8'hC1, 8, 0, 0, 0, 1, 1);
    chk("R4 other mode eight bit", last_byte, 8'hC1);
  endtask

  task automatic t_parity();
    int n0 = pushes;
    cfg_word = mkcfg(0, 1, 0, 0, 1, 1, 1);
    send(8'h37, 8, 1, 0, 0, 1, 1);
    chk("R5 good even no flag", status_word[16], 0);
    send(8'h37, 8, 1, 0, 1, 1, 1);
    chk("R5 bad even flag", status_word[16], 1);
    chk("R5 byte kept", last_byte, 8'h37);
    chk("R5 pushes", pushes - n0, 2);
    cfg_word = mkcfg(0, 1, 1, 0, 1, 1, 1);
    send(8'h29, 8, 1, 1, 0, 1, 1);
    chk("R9 sticky after good frame", status_word[16], 1);
    chk("R5 odd byte", last_byte, 8'h29);
    strobe(6'b000100);
    chk("R9 PE cleared", status_word[16], 0);
    send(8'h29, 8, 1, 1, 1, 1, 1);
    chk("R5 bad odd flag", status_word[16], 1);
    strobe(6'b000100);
    cfg_word = mkcfg(0, 1, 1, 0, 0, 1, 1);
    send(8'h29, 8, 1, 1, 1, 1, 1);
    chk("R5 detect disabled", status_word[16], 0);
  endtask

  task automatic t_twostop();
    int n0;
    cfg_word = mkcfg(0, 0, 0, 1, 1, 1, 1);
    n0 = pushes;
    @(negedge clk); rxd = 1'b0; hold(BIT_CLK);
    for (int i = 0; i < 8; i++) begin rxd = 1'(8'h96 >> i); hold(BIT_CLK); end
    rxd = 1'b1; hold(BIT_CLK);
    rxd = 1'b0; hold(24);
    rxd = 1'b1; hold(14 * BIT_CLK);
    chk("R6 one push only", pushes - n0, 1);
    chk("R6 byte", last_byte, 8'h96);
  endtask

  task automatic t_framing();
    int n0 = pushes;
    cfg_word = mkcfg(0, 0, 0, 0, 1, 1, 1);
    send(8'h81, 8, 0, 0, 0, 0, 1);
    chk("R7 FE set", status_word[17], 1);
    chk("R7 byte kept", last_byte, 8'h81);
    chk("R7 one push", pushes - n0, 1);
    chk("R10 err_req high", err_req, 1);
    strobe(6'b000100);
    chk("R9 PE clear keeps FE", status_word[17], 1);
    strobe(6'b001000);
    chk("R9 FE cleared", status_word[17], 0);
    chk("R10 err_req low", err_req, 0);
    cfg_word = mkcfg(0, 0, 0, 0, 1, 0, 1);
    send(8'h81, 8, 0, 0, 0, 0, 1);
    chk("R7 detect disabled", status_word[17], 0);
  endtask

  task automatic t_overrun();
    int n0 = pushes;
    cfg_word = mkcfg(0, 0, 0, 0, 1, 1, 1);
    fifo_full = 1'b1;
    send(8'h11, 8, 0, 0, 0, 1, 1);
    chk("R8 dropped", pushes - n0, 0);
    chk("R8 ROE set", status_word[19], 1);
    chk("R10 err_req overrun", err_req, 1);
    strobe(6'b100000);
    chk("R9 ROE cleared", status_word[19], 0);
    cfg_word = mkcfg(0, 0, 0, 0, 1, 1, 0);
    send(8'h22, 8, 0, 0, 0, 1, 1);
    chk("R8 disabled no flag", status_word[19], 0);
    chk("R8 disabled still dropped", pushes - n0, 0);
    fifo_full = 1'b0;
    send(8'h33, 8, 0, 0, 0, 1, 1);
    chk("R8 resumes", last_byte, 8'h33);
  endtask

  task automatic t_clear_same_cycle();
    cfg_word = mkcfg(0, 1, 0, 0, 1, 1, 1);
    fork
      send(8'h5E, 8, 1, 0, 1, 1, 1);
      begin
        @(negedge clk);
        while (!push_valid) @(negedge clk);
        stb_we = 1'b1; stb_word = 6'b000100;
        @(negedge clk); stb_we = 1'b0; stb_word = '0;
      end
    join
    chk("R9 clear wins same cycle", status_word[16], 0);
    chk("R9 byte", last_byte, 8'h5E);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    hold(10);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_eight();
    t_seven();
    t_parity();
    t_twostop();
    t_framing();
    t_overrun();
    t_clear_same_cycle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule